// File: doc/BRIEF.md
# Dual-Edge Period Capture Timer

This block is a free-running counter joined to a pair of capture channels that share one input pin. The first channel latches the counter on a chosen edge of the pin. The second channel latches it on the next chosen edge. The two values form one timestamp pair. Their difference, taken modulo the counter range, gives the period of the signal when both channels select rising edges. It gives the pulse width when the first channel selects rising and the second selects falling.

The pin passes through a synchronizer before edges are detected. The counter runs from a programmable start value up to a programmable limit, then wraps. It advances once every 2^PS clocks. A pair is reported complete only through the second channel's flag. That flag can raise an interrupt line or a DMA request, and a DMA acknowledge pulse clears it. In one-shot mode the pair stops after one capture until software re-arms it. In continuous mode the pair re-arms itself, so software only has to clear the second flag.

Software reaches the block through a small register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `pair_period_timer`

## Requirements
- R1: After reset, both flags, both capture values, the counter and the configuration are zero, the limit register is all ones, and `dma_req` and `irq` are low.
- R2: The control register is at address 0. Its fields are: bits [2:0] PS, bit 3 run, bit 4 continuous, bit 5 DMA enable, bit 6 interrupt enable, bits [8:7] edge select of the first channel, bits [10:9] edge select of the second channel. While run is set, the counter advances once every 2^PS clocks.
- R3: The start value is at address 1 and the limit is at address 2. A tick with the counter at the limit reloads the start value. While run is clear, the counter holds the start value. The counter is read at address 6.
- R4: The pin passes through a two-flop synchronizer and then an edge detector. A pin level first sampled at clock edge k is acted on at clock edge k+2. The capture stores the counter value held just before that edge.
- R5: The edge select encoding is 00 none, 01 rising, 10 falling, 11 both. The first channel captures on its selected edge. The second channel captures on the next edge that matches its own select. Capture values are read at address 4 (first) and address 5 (second).
- R6: The first flag (status bit 0, address 3) sets when the first channel captures. The second flag (status bit 1) sets only when the second capture completes a pair.
- R7: In one-shot mode, after a pair the channels ignore all edges until a write to address 3 with bit 2 set re-arms them.
- R8: In continuous mode, the pair re-arms after each completion. Clearing only the second flag is enough: when it next sets, both capture registers hold the newest pair.
- R9: `dma_req` is high when the second flag, DMA enable and interrupt enable are all set. `irq` is high when the second flag and interrupt enable are set and DMA enable is clear.
- R10: A `dma_ack` pulse clears the second flag. A capture that sets the flag in the same cycle wins.
- R11: The second capture minus the first capture, modulo 2^CNT_W, equals the number of counter ticks between the two edges.
- R12: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 leaves it unchanged. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous signal under measurement |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | BUS_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | BUS_W | Register read data (combinational) |
| dma_ack | input | 1 | DMA acknowledge pulse, clears the second flag |
| dma_req | output | 1 | DMA request for a completed pair |
| irq | output | 1 | Interrupt request for a completed pair |

## Verification
The assertions assume the following about the inputs:
- The start value and the limit are rewritten only while the counter is not at its limit.
- `dma_ack` arrives as a single-cycle pulse.
- The pin holds each level for longer than the synchronizer depth.

The stimulus writes configuration only between scenarios, with run cleared. It drives the pin in square waves whose phases last at least seven clocks. It pulses `dma_ack` for exactly one clock.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
   typedef enum logic [1:0] {
      ST_WAIT_A = 2'd0,
      ST_WAIT_B = 2'd1,
      ST_HELD   = 2'd2
   } cap_state_e;

   localparam logic [2:0] ADR_CTRL  = 3'd0;
   localparam logic [2:0] ADR_START = 3'd1;
   localparam logic [2:0] ADR_LIMIT = 3'd2;
   localparam logic [2:0] ADR_STAT  = 3'd3;
   localparam logic [2:0] ADR_CAPA  = 3'd4;
   localparam logic [2:0] ADR_CAPB  = 3'd5;
   localparam logic [2:0] ADR_COUNT = 3'd6;

   localparam int CTRL_RUN  = 3;
   localparam int CTRL_CONT = 4;
   localparam int CTRL_DMA  = 5;
   localparam int CTRL_IEN  = 6;
   localparam int CTRL_SELA = 7;
   localparam int CTRL_SELB = 9;
   localparam int CTRL_BITS = 11;
endpackage

// File: rtl/ppt_sync.sv
module ppt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_depth
      $error("ppt_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= pin;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last;
   assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/ppt_counter.sv
module ppt_counter #(
   parameter int CNT_W = 16,
   parameter int PS_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PS_W-1:0]  ps,
   input  logic [CNT_W-1:0] start_val,
   input  logic [CNT_W-1:0] limit_val,
   output logic [CNT_W-1:0] cnt,
   output logic             tick
);
   localparam int DIV_W = (1 << PS_W) - 1;

   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("ppt_counter PS_W must be 1..4");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("ppt_counter CNT_W must be at least 2");
   end

   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] div_limit;

   assign div_limit = ~({DIV_W{1'b1}} << ps);
   assign tick      = run && (div_cnt == div_limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_cnt <= '0;
         cnt     <= '0;
      end else if (!run) begin
         div_cnt <= '0;
         cnt     <= start_val;
      end else if (tick) begin
         div_cnt <= '0;
         cnt     <= (cnt == limit_val) ? start_val : cnt + CNT_W'(1);
      end else begin
         div_cnt <= div_cnt + DIV_W'(1);
      end
   end
endmodule

// File: rtl/ppt_capture_pair.sv
module ppt_capture_pair
   import ppt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             continuous,
   input  logic [1:0]       sel_a,
   input  logic [1:0]       sel_b,
   input  logic             rise,
   input  logic             fall,
   input  logic             rearm,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap_a,
   output logic [CNT_W-1:0] cap_b,
   output logic             set_a,
   output logic             set_b,
   output cap_state_e       state
);
   logic hit_a, hit_b;

   assign hit_a = (sel_a[0] & rise) | (sel_a[1] & fall);
   assign hit_b = (sel_b[0] & rise) | (sel_b[1] & fall);
   assign set_a = run && (state == ST_WAIT_A) && hit_a;
   assign set_b = run && (state == ST_WAIT_B) && hit_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_WAIT_A;
         cap_a <= '0;
         cap_b <= '0;
      end else if (!run) begin
         state <= ST_WAIT_A;
      end else begin
         if (set_a) cap_a <= cnt;
         if (set_b) cap_b <= cnt;
         case (state)
            ST_WAIT_A: if (hit_a) state <= ST_WAIT_B;
            ST_WAIT_B: if (hit_b) state <= continuous ? ST_WAIT_A : ST_HELD;
            ST_HELD:   if (rearm) state <= ST_WAIT_A;
            default:   state <= ST_WAIT_A;
         endcase
      end
   end
endmodule

// File: rtl/pair_period_timer.sv
module pair_period_timer
   import ppt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 16,
   parameter int PS_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_pin,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [BUS_W-1:0] wr_data,
   input  logic [2:0]       rd_addr,
   output logic [BUS_W-1:0] rd_data,
   input  logic             dma_ack,
   output logic             dma_req,
   output logic             irq
);
   if (BUS_W < CNT_W || BUS_W < CTRL_BITS) begin : g_bad_bus
      $error("pair_period_timer BUS_W too narrow");
   end
   if (PS_W != 3) begin : g_bad_psw
      $error("control layout holds a 3-bit prescale field");
   end

   logic [BUS_W-1:0] ctrl_q;
   logic [CNT_W-1:0] start_val, limit_val, cnt, cap_a, cap_b;
   logic             flag_a, flag_b, tick, rise, fall, set_a, set_b, rearm;
   logic             run, cont_mode, dma_en, irq_en, stat_wr;
   logic [PS_W-1:0]  ps;
   logic [1:0]       sel_a, sel_b;
   cap_state_e       state;

   assign ps        = ctrl_q[PS_W-1:0];
   assign run       = ctrl_q[CTRL_RUN];
   assign cont_mode = ctrl_q[CTRL_CONT];
   assign dma_en    = ctrl_q[CTRL_DMA];
   assign irq_en    = ctrl_q[CTRL_IEN];
   assign sel_a     = ctrl_q[CTRL_SELA +: 2];
   assign sel_b     = ctrl_q[CTRL_SELB +: 2];
   assign stat_wr   = wr_en && (wr_addr == ADR_STAT);
   assign rearm     = stat_wr && wr_data[2];

   ppt_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(rise), .fall(fall)
   );

   ppt_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) counter_i (
      .clk(clk), .rst_n(rst_n), .run(run), .ps(ps),
      .start_val(start_val), .limit_val(limit_val), .cnt(cnt), .tick(tick)
   );

   ppt_capture_pair #(.CNT_W(CNT_W)) pair_i (
      .clk(clk), .rst_n(rst_n), .run(run), .continuous(cont_mode),
      .sel_a(sel_a), .sel_b(sel_b), .rise(rise), .fall(fall), .rearm(rearm),
      .cnt(cnt), .cap_a(cap_a), .cap_b(cap_b), .set_a(set_a), .set_b(set_b),
      .state(state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         start_val <= '0;
         limit_val <= '1;
      end else if (wr_en) begin
         if (wr_addr == ADR_CTRL)  ctrl_q    <= wr_data;
         if (wr_addr == ADR_START) start_val <= wr_data[CNT_W-1:0];
         if (wr_addr == ADR_LIMIT) limit_val <= wr_data[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_a <= 1'b0;
         flag_b <= 1'b0;
      end else begin
         if (set_a)                        flag_a <= 1'b1;
         else if (stat_wr && wr_data[0])   flag_a <= 1'b0;
         if (set_b)                        flag_b <= 1'b1;
         else if ((stat_wr && wr_data[1]) || dma_ack) flag_b <= 1'b0;
      end
   end

   assign dma_req = flag_b && dma_en && irq_en;
   assign irq     = flag_b && irq_en && !dma_en;

   always_comb begin
      case (rd_addr)
         ADR_CTRL:  rd_data = ctrl_q;
         ADR_START: rd_data = BUS_W'(start_val);
         ADR_LIMIT: rd_data = BUS_W'(limit_val);
         ADR_STAT:  rd_data = BUS_W'({flag_b, flag_a});
         ADR_CAPA:  rd_data = BUS_W'(cap_a);
         ADR_CAPB:  rd_data = BUS_W'(cap_b);
         ADR_COUNT: rd_data = BUS_W'(cnt);
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/ppt_checker.sv
module ppt_checker
   import ppt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] start_val,
   input logic [CNT_W-1:0] limit_val,
   input logic [CNT_W-1:0] cap_a,
   input logic [CNT_W-1:0] cap_b,
   input cap_state_e       state,
   input logic             set_b,
   input logic             flag_b,
   input logic             dma_ack,
   input logic             dma_req,
   input logic             irq
);
   p_req_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(dma_req && irq));

   p_pair_from_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_b) |-> $past(state) == ST_WAIT_B);

   p_held_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_HELD |=> $stable(cap_a) && $stable(cap_b));

   p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack && !set_b) |=> !flag_b);

   p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt == limit_val) |=> cnt == $past(start_val));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == $past(start_val));
endmodule

bind pair_period_timer ppt_checker #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt(cnt),
   .start_val(start_val), .limit_val(limit_val), .cap_a(cap_a),
   .cap_b(cap_b), .state(state), .set_b(set_b), .flag_b(flag_b),
   .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq)
);

// File: tb/pair_period_timer_tb_top.sv
module pair_period_timer_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cap_pin = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [2:0]   rd_addr;
   logic [W-1:0] rd_data;
   logic         dma_ack = 1'b0;
   logic         dma_req, irq;

   logic [2:0]   sweep_addr = '0;
   logic [2:0]   dir_addr = '0;
   logic         use_dir = 1'b0;
   assign rd_addr = use_dir ? dir_addr : sweep_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   pair_period_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq)
   );

   // behavioural reference, advanced once per rising edge
   int m_ctrl, m_start, m_limit, m_cnt, m_div, m_state;
   int m_capa, m_capb, m_fa, m_fb, s1, s2, lst;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_start = 0; m_limit = 'hFFFF; m_cnt = 0; m_div = 0;
         m_state = 0; m_capa = 0; m_capb = 0; m_fa = 0; m_fb = 0;
         s1 = 0; s2 = 0; lst = 0;
      end else begin
         int ps, run, cont, sa, sb, rs, fl, ha, hb, sta, stb, tk, rearm, sw;
         ps = m_ctrl & 7; run = (m_ctrl >> 3) & 1; cont = (m_ctrl >> 4) & 1;
         sa = (m_ctrl >> 7) & 3; sb = (m_ctrl >> 9) & 3;
         rs = (s2 && !lst); fl = (!s2 && lst);
         ha = ((sa & 1) && rs) || ((sa & 2) && fl);
         hb = ((sb & 1) && rs) || ((sb & 2) && fl);
         sta = run && m_state == 0 && ha;
         stb = run && m_state == 1 && hb;
         sw = wr_en && wr_addr == 3;
         rearm = sw && wr_data[2];
         if (sta) m_capa = m_cnt;
         if (stb) m_capb = m_cnt;
         if (!run) m_state = 0;
         else if (m_state == 0 && ha) m_state = 1;
         else if (m_state == 1 && hb) m_state = cont ? 0 : 2;
         else if (m_state == 2 && rearm) m_state = 0;
         tk = run && (m_div == (1 << ps) - 1);
         if (!run) begin m_div = 0; m_cnt = m_start; end
         else if (tk) begin
            m_div = 0;
            m_cnt = (m_cnt == m_limit) ? m_start : (m_cnt + 1) & 'hFFFF;
         end else m_div = m_div + 1;
         if (sta) m_fa = 1; else if (sw && wr_data[0]) m_fa = 0;
         if (stb) m_fb = 1; else if ((sw && wr_data[1]) || dma_ack) m_fb = 0;
         if (wr_en && wr_addr == 0) m_ctrl = wr_data;
         if (wr_en && wr_addr == 1) m_start = wr_data;
         if (wr_en && wr_addr == 2) m_limit = wr_data;
         lst = s2; s2 = s1; s1 = cap_pin;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference, mid high phase
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         int exp, mdma, mirq;
         string tag;
         case (rd_addr)
            3'd0: begin exp = m_ctrl;  tag = "R2"; end
            3'd1: begin exp = m_start; tag = "R3"; end
            3'd2: begin exp = m_limit; tag = "R3"; end
            3'd3: begin exp = m_fb * 2 + m_fa; tag = "R6"; end
            3'd4: begin exp = m_capa; tag = "R4"; end
            3'd5: begin exp = m_capb; tag = "R4"; end
            3'd6: begin exp = m_cnt;  tag = "R2"; end
            default: begin exp = 0; tag = "R5"; end
         endcase
         chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
         mdma = m_fb && ((m_ctrl >> 5) & 1) && ((m_ctrl >> 6) & 1);
         mirq = m_fb && ((m_ctrl >> 6) & 1) && !((m_ctrl >> 5) & 1);
         chk(dma_req == mdma[0] && irq == mirq[0], "R9",
             int'({dma_req, irq}), mdma * 2 + mirq);
      end
   end

   always @(negedge clk) sweep_addr <= sweep_addr + 3'd1;

   task automatic wr(input logic [2:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(negedge clk);
      dir_addr = a; use_dir = 1'b1;
      #1 v = int'(rd_data);
      use_dir = 1'b0;
   endtask

   task automatic cfg(input int ps, input int run, input int cont, input int dma,
                      input int ien, input int sa, input int sb);
      wr(3'd0, ps | (run << 3) | (cont << 4) | (dma << 5) | (ien << 6) |
               (sa << 7) | (sb << 9));
   endtask

   task automatic wave(input int hi, input int lo, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cap_pin = 1'b1;
         repeat (hi) @(negedge clk);
         cap_pin = 1'b0;
         repeat (lo - 1) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic restart();
      cfg(0, 0, 0, 0, 0, 0, 0);
      wr(3'd3, 3);
   endtask

   initial begin
      #(200000 * 20);
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int a, b, a0, b0, v, c0, c1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      rd(3'd3, v); chk(v == 0, "R1 flags", v, 0);
      rd(3'd6, v); chk(v == 0, "R1 count", v, 0);
      rd(3'd2, v); chk(v == 'hFFFF, "R1 limit", v, 'hFFFF);
      chk(dma_req == 0 && irq == 0, "R1 requests", int'({dma_req, irq}), 0);

      // R2 prescale divide by 8
      cfg(3, 1, 0, 0, 0, 0, 0);
      rd(3'd6, c0); repeat (63) @(negedge clk); rd(3'd6, c1);
      chk(c1 - c0 == 8, "R2 prescale", c1 - c0, 8);

      // R5 R11 one-shot period, rising/rising
      restart(); cfg(0, 1, 0, 0, 0, 1, 1);
      wave(10, 10, 2);
      rd(3'd4, a); rd(3'd5, b);
      chk(((b - a) & 'hFFFF) == 20, "R11 period", (b - a) & 'hFFFF, 20);
      rd(3'd3, v); chk(v == 3, "R6 pair flags", v, 3);
      // R7 ignore edges while held
      wave(10, 10, 2);
      rd(3'd4, a0); rd(3'd5, b0);
      chk(a0 == a && b0 == b, "R7 held", a0, a);
      wr(3'd3, 4 | 3);
      wave(10, 10, 2);
      rd(3'd4, a0); rd(3'd5, b0);
      chk(a0 != a && ((b0 - a0) & 'hFFFF) == 20, "R7 rearm", (b0 - a0) & 'hFFFF, 20);

      // R8 continuous, divide by 4
      restart(); cfg(2, 1, 1, 0, 0, 1, 1);
      wave(20, 20, 2);
      rd(3'd4, a); rd(3'd5, b);
      chk(((b - a) & 'hFFFF) == 10, "R8 first pair", (b - a) & 'hFFFF, 10);
      wr(3'd3, 2);
      rd(3'd3, v); chk(v == 1, "R12 clear second only", v, 1);
      wave(20, 20, 2);
      rd(3'd3, v); chk(v == 3, "R8 flag again", v, 3);
      rd(3'd4, a0); rd(3'd5, b0);
      chk(a0 != a && ((b0 - a0) & 'hFFFF) == 10, "R8 latest pair", (b0 - a0) & 'hFFFF, 10);

      // R5 pulse width rising then falling
      restart(); cfg(0, 1, 0, 0, 0, 1, 2);
      wave(7, 13, 1);
      rd(3'd4, a); rd(3'd5, b);
      chk(((b - a) & 'hFFFF) == 7, "R5 width", (b - a) & 'hFFFF, 7);

      // R5 first channel disabled: no capture
      restart(); cfg(0, 1, 0, 0, 0, 0, 1);
      wave(10, 10, 2);
      rd(3'd3, v); chk(v == 0, "R5 none select", v, 0);

      // R3 wrap with start 4 limit 15
      restart(); wr(3'd1, 4); wr(3'd2, 15);
      rd(3'd6, v); chk(v == 4, "R3 idle start", v, 4);
      cfg(0, 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 30; i++) begin
         rd(3'd6, v);
         if (v < 4 || v > 15) chk(1'b0, "R3 range", v, 15);
      end
      chk(1'b1, "R3 range", 0, 0);
      restart(); wr(3'd1, 0); wr(3'd2, 'hFFFF);

      // R9 R10 DMA request and acknowledge
      cfg(0, 1, 0, 1, 1, 1, 1);
      wave(10, 10, 2);
      chk(dma_req == 1 && irq == 0, "R9 dma", int'({dma_req, irq}), 2);
      wr(3'd3, 0);
      rd(3'd3, v); chk(v == 3, "R12 write zero", v, 3);
      @(negedge clk); dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
      rd(3'd3, v); chk(v == 1, "R10 ack clears", v, 1);
      chk(dma_req == 0, "R10 request drop", int'(dma_req), 0);
      restart(); cfg(0, 1, 0, 0, 1, 1, 1);
      wave(10, 10, 2);
      chk(irq == 1 && dma_req == 0, "R9 irq", int'({dma_req, irq}), 1);

      repeat (5) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule